// File: doc/BRIEF.md
# Program Counter with Constant-Load Sequencing

This block is the program counter and fetch controller of a machine whose program memory is separate from its data memory. The counter has two registers. The master register holds the program counter value. The slave register drives the program-memory address. In normal running the slave takes the incremented master value and the master then copies the slave back, so both registers advance together. All state moves only on clock edges where the phase-3 strobe `ph3_i` is high. On other edges every register holds its value.

A table of constants stored in program memory cannot be reached with a data-memory access, so a dedicated load-constant instruction is provided. When the decoder flags it, the slave register is pointed at the selected address register's value while the master keeps the real program counter. During the next instruction cycle the word read from that address goes into the 16-bit data register and not into the instruction register. The instruction register stays cleared, so a NOP executes. The slave then returns to the master value and fetching resumes where it stopped. The same path into the data register also stores the program counter on a subroutine call.

Top module: `pc_fetch_ldc`

## Requirements
- R1: A synchronous active-low reset sets the address to 0 and the data register to 0, clears any pending constant fetch, and sets `nop_o` to 1. `ir_load_o` is 0 while reset is asserted.
- R2: On a clock edge with `ph3_i` low, `pmem_addr_o`, `dh_o` and `nop_o` keep their values, and `ir_load_o` is 0.
- R3: On a normal step (`ph3_i` high, no fetch pending, `ldc_i` low), `ir_load_o` is 1 during that cycle. After the edge the address is the previous address plus one and `nop_o` is 0.
- R4: On a step with `ldc_i` high and no fetch pending, `ir_load_o` is 0 during that cycle. After the edge `pmem_addr_o` equals the `areg_i` value sampled at the edge, and `nop_o` is 1.
- R5: On the step that follows a load-constant, `ir_load_o` is 0 and `dh_o` takes all 16 bits of `pmem_data_i` read at the constant address. `nop_o` stays 1.
- R6: After the constant fetch, `pmem_addr_o` returns to the program counter value held before the load-constant. The next step loads the instruction register from that address and then increments it.
- R7: On a step with `call_i` high and no fetch pending, `dh_o` takes the program counter zero-extended to 16 bits. This also holds when `ldc_i` is high on the same step.
- R8: A `ldc_i` strobe on the step that completes a pending constant fetch is ignored. The address returns to the program counter and no second fetch starts.
- R9: A `call_i` strobe on the step that completes a pending constant fetch is ignored. `dh_o` receives the constant.
- R10: The program counter wraps from 0xFFF to 0x000 on a normal step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph3_i | input | 1 | Phase-3 strobe; state updates only on edges where it is high |
| ldc_i | input | 1 | Decoded load-constant instruction |
| call_i | input | 1 | Decoded subroutine call; copies the program counter into the data register |
| areg_i | input | 12 | Value of the selected address register |
| pmem_data_i | input | 16 | Word read from program memory at `pmem_addr_o` |
| pmem_addr_o | output | 12 | Program-memory address (slave register) |
| ir_load_o | output | 1 | Instruction-register load enable for this edge |
| nop_o | output | 1 | Instruction register is cleared; a NOP executes |
| dh_o | output | 16 | Data register value |

## Verification
The assertions check these rules on every cycle:
- registers hold on edges where the phase-3 strobe is low;
- the address increments on a normal step and jumps to the address register value on a load-constant;
- the fetched word lands in the data register, and the call path loads the zero-extended counter;
- the instruction register never loads while a fetch is pending;
- the slave returns to the master value after a constant fetch.

Some behaviour can only be shown by the bench's scenarios, because each depends on a sequence spanning several steps:
- the instruction flow resumes at the exact pre-load address;
- strobes that arrive during a pending fetch are dropped;
- the counter wraps at the top of the address space;
- a reset asserted in the middle of a constant fetch cancels it.

// File: rtl/pc_fetch_pkg.sv
// Shared selector encodings for the program-counter and fetch block.
// Assumes: each consumer decodes these enums fully; unlisted codes mean hold.
package pc_fetch_pkg;

    // Source for the slave register (program-memory address)
    typedef enum logic [1:0] {
        SLV_HOLD   = 2'd0,
        SLV_INC    = 2'd1,
        SLV_AREG   = 2'd2,
        SLV_MASTER = 2'd3
    } slv_sel_e;

    // Source for the data register
    typedef enum logic [1:0] {
        DH_HOLD = 2'd0,
        DH_CODE = 2'd1,
        DH_PC   = 2'd2
    } dh_sel_e;

endpackage

// File: rtl/pc_fetch_ctrl.sv
// Sequencer for normal fetch and the two-step constant load.
// Assumes: ph3_i marks the one edge per instruction cycle at which state moves;
// ldc_i and call_i are valid whenever ph3_i is high.
module pc_fetch_ctrl
    import pc_fetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ph3_i,
    input  logic     ldc_i,
    input  logic     call_i,
    output slv_sel_e slv_sel_o,
    output logic     mst_load_o,
    output dh_sel_e  dh_sel_o,
    output logic     ir_load_o,
    output logic     nop_o,
    output logic     pend_o
);

    logic pend_q;
    logic nop_q;
    logic ir_load;

    // Decode this edge's register transfers from the strobes and pending flag
    always_comb begin
        slv_sel_o  = SLV_HOLD;
        mst_load_o = 1'b0;
        dh_sel_o   = DH_HOLD;
        ir_load    = 1'b0;
        if (ph3_i) begin
            if (pend_q) begin
                dh_sel_o  = DH_CODE;
                slv_sel_o = SLV_MASTER;
            end else begin
                if (call_i) begin
                    dh_sel_o = DH_PC;
                end
                if (ldc_i) begin
                    slv_sel_o = SLV_AREG;
                end else begin
                    slv_sel_o  = SLV_INC;
                    mst_load_o = 1'b1;
                    ir_load    = 1'b1;
                end
            end
        end
    end

    // Track the pending constant fetch and the cleared-instruction flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            nop_q  <= 1'b1;
        end else if (ph3_i) begin
            if (pend_q) begin
                pend_q <= 1'b0;
            end else if (ldc_i) begin
                pend_q <= 1'b1;
                nop_q  <= 1'b1;
            end else begin
                nop_q  <= 1'b0;
            end
        end
    end

    assign ir_load_o = ir_load & rst_n;
    assign nop_o     = nop_q;
    assign pend_o    = pend_q;

endmodule

// File: rtl/pc_fetch_counter.sv
// Master/slave program counter. The slave drives the program-memory address.
// Assumes: the master copies the slave's new value only when mst_load_i is high.
module pc_fetch_counter
    import pc_fetch_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  slv_sel_e        slv_sel_i,
    input  logic            mst_load_i,
    input  logic [PC_W-1:0] areg_i,
    output logic [PC_W-1:0] master_o,
    output logic [PC_W-1:0] slave_o
);

    logic [PC_W-1:0] master_q;
    logic [PC_W-1:0] slave_q;
    logic [PC_W-1:0] slave_n;

    // Choose the slave's next value: incremented master, address register, master, or hold
    always_comb begin
        case (slv_sel_i)
            SLV_INC:    slave_n = master_q + PC_W'(1);
            SLV_AREG:   slave_n = areg_i;
            SLV_MASTER: slave_n = master_q;
            default:    slave_n = slave_q;
        endcase
    end

    // Update the slave each edge; the master follows the slave only on a normal advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            slave_q <= slave_n;
            if (mst_load_i) begin
                master_q <= slave_n;
            end
        end
    end

    assign master_o = master_q;
    assign slave_o  = slave_q;

endmodule

// File: rtl/pc_fetch_dreg.sv
// Data register loaded from program-memory code or from the program counter.
// Assumes: DW >= PC_W; the counter value is zero-extended on a call.
module pc_fetch_dreg
    import pc_fetch_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dh_sel_e         dh_sel_i,
    input  logic [DW-1:0]   code_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [DW-1:0]   dh_o
);

    localparam int PAD_W = DW - PC_W;

    logic [DW-1:0] pc_ext;
    logic [DW-1:0] dh_q;

    // Widen the counter value to the data width
    generate
        if (PAD_W > 0) begin : g_pad
            assign pc_ext = {{PAD_W{1'b0}}, pc_i};
        end else begin : g_nopad
            assign pc_ext = pc_i[DW-1:0];
        end
    endgenerate

    // Overwrite the register with the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dh_q <= '0;
        end else begin
            case (dh_sel_i)
                DH_CODE: dh_q <= code_i;
                DH_PC:   dh_q <= pc_ext;
                default: dh_q <= dh_q;
            endcase
        end
    end

    assign dh_o = dh_q;

endmodule

// File: rtl/pc_fetch_ldc.sv
// Top: program counter, fetch sequencing and constant-load data path.
// Assumes: pmem_data_i is the program-memory word at pmem_addr_o in the same cycle.
module pc_fetch_ldc
    import pc_fetch_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ph3_i,
    input  logic            ldc_i,
    input  logic            call_i,
    input  logic [PC_W-1:0] areg_i,
    input  logic [DW-1:0]   pmem_data_i,
    output logic [PC_W-1:0] pmem_addr_o,
    output logic            ir_load_o,
    output logic            nop_o,
    output logic [DW-1:0]   dh_o
);

    slv_sel_e        slv_sel;
    dh_sel_e         dh_sel;
    logic            mst_load;
    logic            fetch_pend;
    logic [PC_W-1:0] pc_master;

    pc_fetch_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph3_i      (ph3_i),
        .ldc_i      (ldc_i),
        .call_i     (call_i),
        .slv_sel_o  (slv_sel),
        .mst_load_o (mst_load),
        .dh_sel_o   (dh_sel),
        .ir_load_o  (ir_load_o),
        .nop_o      (nop_o),
        .pend_o     (fetch_pend)
    );

    pc_fetch_counter #(.PC_W(PC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .slv_sel_i  (slv_sel),
        .mst_load_i (mst_load),
        .areg_i     (areg_i),
        .master_o   (pc_master),
        .slave_o    (pmem_addr_o)
    );

    pc_fetch_dreg #(.PC_W(PC_W), .DW(DW)) u_dreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .dh_sel_i (dh_sel),
        .code_i   (pmem_data_i),
        .pc_i     (pc_master),
        .dh_o     (dh_o)
    );

endmodule

// File: rtl/pc_fetch_ldc_chk.sv
// Property checker for pc_fetch_ldc, attached by bind.
// Assumes: pc_master and fetch_pend are the top's master register and pending flag.
module pc_fetch_ldc_chk #(
    parameter int PC_W = 12,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ph3_i,
    input logic            ldc_i,
    input logic            call_i,
    input logic [PC_W-1:0] areg_i,
    input logic [DW-1:0]   pmem_data_i,
    input logic [PC_W-1:0] pmem_addr_o,
    input logic            ir_load_o,
    input logic            nop_o,
    input logic [DW-1:0]   dh_o,
    input logic [PC_W-1:0] pc_master,
    input logic            fetch_pend
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pmem_addr_o == '0) && (dh_o == '0) && nop_o && !fetch_pend); // R1

    AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph3_i |=> $stable(pmem_addr_o) && $stable(dh_o) && $stable(nop_o)); // R2

    AST_NO_IR_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph3_i |-> !ir_load_o); // R2

    AST_NORMAL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph3_i && !fetch_pend && !ldc_i) |=>
            (pmem_addr_o == PC_W'($past(pmem_addr_o) + PC_W'(1))) && !nop_o); // R3

    AST_LDC_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph3_i && !fetch_pend && ldc_i) |=> (pmem_addr_o == $past(areg_i)) && nop_o); // R4

    AST_CONST_TO_DH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph3_i && fetch_pend) |=> dh_o == $past(pmem_data_i)); // R5

    AST_NO_IR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pend |-> !ir_load_o); // R5

    AST_RETURN_TO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (ph3_i && fetch_pend) |=> (pmem_addr_o == $past(pc_master)) && !fetch_pend); // R6

    AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph3_i && !fetch_pend && call_i) |=> dh_o == DW'($past(pc_master))); // R7

endmodule

bind pc_fetch_ldc pc_fetch_ldc_chk #(.PC_W(PC_W), .DW(DW)) u_chk (.*);

// File: tb/pc_fetch_ldc_test.sv
module pc_fetch_ldc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph3 = 1'b0;
    logic        ldc = 1'b0;
    logic        call = 1'b0;
    logic [11:0] areg = '0;
    logic [15:0] pmem_data;
    logic [11:0] pmem_addr;
    logic        ir_load;
    logic        nop;
    logic [15:0] dh;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [11:0] m_pc, m_sl, m_saved;
    logic        m_pend, m_nop;
    logic [15:0] m_dh;

    always #10 clk = ~clk;

    // Program memory contents, computed from the address
    function automatic logic [15:0] memf(input logic [11:0] a);
        return (16'(a) * 16'd40503) ^ 16'h5A3C;
    endfunction

    assign pmem_data = memf(pmem_addr);

    pc_fetch_ldc uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph3_i       (ph3),
        .ldc_i       (ldc),
        .call_i      (call),
        .areg_i      (areg),
        .pmem_data_i (pmem_data),
        .pmem_addr_o (pmem_addr),
        .ir_load_o   (ir_load),
        .nop_o       (nop),
        .dh_o        (dh)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_ir(input logic r, input logic p, input logic l);
        return r && p && !m_pend && !l;
    endfunction

    task automatic model_step(input logic r, input logic p, input logic l,
                              input logic c, input logic [11:0] ar);
        if (!r) begin
            m_pc = '0; m_sl = '0; m_pend = 1'b0; m_nop = 1'b1; m_dh = '0;
        end else if (p) begin
            if (m_pend) begin
                m_dh   = memf(m_sl);
                m_sl   = m_pc;
                m_pend = 1'b0;
            end else begin
                if (c) m_dh = {4'h0, m_pc};
                if (l) begin
                    m_sl = ar; m_pend = 1'b1; m_nop = 1'b1;
                end else begin
                    m_pc = m_pc + 12'd1; m_sl = m_pc; m_nop = 1'b0;
                end
            end
        end
    endtask

    // One instruction-cycle edge: drive, check the enable, clock, check the state
    task automatic cyc(input logic r, input logic p, input logic l, input logic c,
                       input logic [11:0] ar, input string req);
        @(negedge clk);
        rst_n = r; ph3 = p; ldc = l; call = c; areg = ar;
        #2;
        chk(req, "ir_load", 32'(ir_load), 32'(exp_ir(r, p, l)));
        @(posedge clk);
        model_step(r, p, l, c, ar);
        #5;
        chk(req, "addr", 32'(pmem_addr), 32'(m_sl));
        chk(req, "dh", 32'(dh), 32'(m_dh));
        chk(req, "nop", 32'(nop), 32'(m_nop));
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_pc = '0; m_sl = '0; m_pend = 1'b0; m_nop = 1'b1; m_dh = '0;

        // R1: reset state
        repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, "R1");

        // R3: plain advance; R2: idle edges hold
        repeat (5) cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R3");
        repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b1, 12'hABC, "R2");

        // R4, R5, R6: full constant load
        m_saved = m_pc;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h7E5, "R4");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R5");
        chk("R5", "dh const", 32'(dh), 32'(memf(12'h7E5)));
        chk("R6", "addr back", 32'(pmem_addr), 32'(m_saved));
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6");
        chk("R6", "advance", 32'(pmem_addr), 32'(m_saved + 12'd1));

        // R8: load-constant strobe on the completing edge is dropped
        m_saved = m_pc;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h123, "R4");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h456, "R8");
        chk("R8", "addr back", 32'(pmem_addr), 32'(m_saved));
        chk("R8", "dh const", 32'(dh), 32'(memf(12'h123)));
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R8");
        chk("R8", "no refetch", 32'(nop), 32'd0);

        // R9: call on the completing edge is dropped
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'hF0F, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R9");
        chk("R9", "dh const", 32'(dh), 32'(memf(12'hF0F)));

        // R7: call alone, then call together with a load-constant
        m_saved = m_pc;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R7");
        chk("R7", "dh pc", 32'(dh), 32'({4'h0, m_saved}));
        m_saved = m_pc;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 12'h3C3, "R7");
        chk("R7", "dh pc ldc", 32'(dh), 32'({4'h0, m_saved}));
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R5");

        // R1: reset in the middle of a constant fetch cancels it
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h555, "R4");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, "R1");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R1");

        // R10: run to the top of the address space and wrap
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 12'h000, "R1");
        for (int i = 0; i < 4095; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R3");
        chk("R10", "at top", 32'(pmem_addr), 32'h0FFF);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R10");
        chk("R10", "wrapped", 32'(pmem_addr), 32'h0000);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic        r, p, l, c;
            logic [11:0] ar;
            string       tag;
            r  = ($urandom_range(0, 99) != 0);
            p  = ($urandom_range(0, 99) < 60);
            l  = ($urandom_range(0, 99) < 20);
            c  = ($urandom_range(0, 99) < 15);
            ar = 12'($urandom());
            if (!r)          tag = "R1";
            else if (!p)     tag = "R2";
            else if (m_pend) tag = (l ? "R8" : (c ? "R9" : "R5"));
            else if (l)      tag = "R4";
            else if (c)      tag = "R7";
            else             tag = "R3";
            cyc(r, p, l, c, ar, tag);
        end

        summary();
        $finish;
    end

endmodule